// File: doc/BRIEF.md
# Paced Transfer Preamble Sequencer

This block is the target-side launcher for a paced data phase on a parallel bus when no training pattern is sent first. One clock tick equals one transfer period. Once a start request is accepted, the block waits a setup delay. The length of that delay depends on whether the previous phase moved data outward. It also holds the first request strobe back until the selection line has been quiet for two deskew intervals.

When both conditions are met, the request strobe begins toggling once per tick. On that same tick the phase-indicator line begins toggling at half the strobe rate, so each of its levels lasts two ticks. After a minimum number of phase-indicator transitions, the block gives a one-tick completion pulse. It then raises a level that permits the data valid state. The data path that follows waits for that level before it drives valid data. Dropping the start request ends the phase at once.

Top module: `pace_preamble_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), and for as long as no phase is running, req_o, p1_o, phase_active, preamble_done and data_ok are all 0. Changes on sel_active while start is low leave all of them at 0.
- R2: When start is seen high in idle with prev_was_out = 0, req_o first reads 1 exactly SHORT_SETUP ticks after the accepting edge. This assumes the deskew condition of R8 is already met.
- R3: When prev_was_out = 1 at the accepting edge, the delay is LONG_SETUP ticks instead. prev_was_out is sampled only at that edge, and later changes to it have no effect on the delay.
- R4: phase_active, req_o and p1_o all go from 0 to 1 on the same edge.
- R5: While phase_active is 1, req_o inverts on every tick. p1_o holds each level for two ticks and changes only on edges where req_o goes to 1. Counting from the first REQ tick as offset 0, req_o = (offset mod 2 == 0) and p1_o = ((offset/2) mod 2 == 0).
- R6: preamble_done is 1 for exactly one tick. That tick is offset 2*(N-1), where N is the PRE_EDGES-th P1 transition and the first assertion counts as the first transition. PRE_EDGES values below 8 are raised to 8.
- R7: data_ok rises together with preamble_done. It stays 1, with P1 still toggling, until the phase ends. It is never 1 outside a running phase.
- R8: req_o cannot rise until sel_active has been sampled low for at least 2*DESKEW_TICKS consecutive edges. Any high sample restarts that count. The first REQ offset after acceptance is therefore max(setup delay, r + 2*DESKEW_TICKS), where r is the edge index of the first low sample after the last high sample.
- R9: start sampled low during setup or during the phase returns the block to idle on that edge, with req_o, p1_o, phase_active and data_ok all 0 after it. rst_n low has the same effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one period per transfer |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Level request to run a paced phase; low stops it |
| prev_was_out | input | 1 | Previous phase moved data outward; selects the long delay |
| sel_active | input | 1 | Selection line asserted on the bus |
| req_o | output | 1 | Request strobe, toggles every tick in phase |
| p1_o | output | 1 | Phase-indicator line, toggles every second tick in phase |
| phase_active | output | 1 | Paced phase running (REQ/P1 generation enabled) |
| preamble_done | output | 1 | One-tick pulse when the minimum preamble ends |
| data_ok | output | 1 | Data valid state permitted |

## Verification
The bench goes after the edges of the delay choice, and after the tick counting, where an off-by-one error would be easy. It checks that a deskew window ending exactly on the setup deadline does not add a tick, and that one ending one tick later does. A design that started P1 one tick after REQ, counted the first P1 assertion wrongly, or pulsed completion at offset 12 or 16 would show up in the per-tick pattern check. A selection glitch during setup must restart the quiet count. A stop or reset in the middle of setup or of the phase must leave every line low on the very next tick, and a later restart must time correctly from scratch.

// File: rtl/pace_pkg.sv
// Shared types and helpers for the paced preamble sequencer.
// Assumes nothing beyond elaboration-time integer arithmetic.
package pace_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_SETUP = 2'd1,
        PS_RUN   = 2'd2
    } pace_state_e;

    // Width needed to hold values 0..n (at least one bit).
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pace_setup_timer.sv
// Setup-delay timer. On load it arms with the short or long delay (in
// ticks) and reports expiry once that many edges have passed, counting
// the loading edge. Assumes SHORT_TICKS and LONG_TICKS are at least 1.
module pace_setup_timer #(
    parameter int SHORT_TICKS = 64,
    parameter int LONG_TICKS  = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic use_long,
    input  logic clear,
    output logic expired
);
    import pace_pkg::*;

    localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int W    = cnt_w(MAXT);
    localparam logic [W-1:0] SHORT_INIT = W'(SHORT_TICKS - 1);
    localparam logic [W-1:0] LONG_INIT  = W'(LONG_TICKS - 1);

    logic [W-1:0] remain;
    logic         armed;

    // Purpose: arm, count down, or disarm the delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            armed  <= 1'b0;
        end else if (load) begin
            remain <= use_long ? LONG_INIT : SHORT_INIT;
            armed  <= 1'b1;
        end else if (clear) begin
            remain <= '0;
            armed  <= 1'b0;
        end else if (armed && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = armed && (remain == '0);

endmodule

// File: rtl/pace_bus_quiet.sv
// Selection-quiet guard. Counts consecutive edges with the selection
// line sampled low, saturating at QUIET_TICKS; any high sample restarts
// the count. Assumes sel_active is already synchronous to clk.
module pace_bus_quiet #(
    parameter int QUIET_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_active,
    output logic quiet_ok
);
    import pace_pkg::*;

    localparam int W = cnt_w(QUIET_TICKS);
    localparam logic [W-1:0] LIMIT = W'(QUIET_TICKS);

    logic [W-1:0] quiet_cnt;

    // Purpose: track how long the selection line has stayed negated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
        end else if (sel_active) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != LIMIT) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assign quiet_ok = (quiet_cnt == LIMIT);

endmodule

// File: rtl/pace_strobe_gen.sv
// REQ / P1 generator with preamble counter. On launch both lines go high
// together; then REQ inverts every tick and P1 every second tick (on the
// edges where REQ returns high). P1 transitions are counted, the first
// assertion included; on the edge of the MIN_EDGES-th transition a
// one-tick pulse is raised and a sticky "met" flag set. Halt clears all.
// Assumes launch and halt are never both high.
module pace_strobe_gen #(
    parameter int MIN_EDGES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic halt,
    output logic req,
    output logic p1,
    output logic done_pulse,
    output logic met
);
    import pace_pkg::*;

    localparam int W = cnt_w(MIN_EDGES);
    localparam logic [W-1:0] LAST     = W'(MIN_EDGES);
    localparam logic [W-1:0] PRE_LAST = W'(MIN_EDGES - 1);

    logic         running;
    logic         half;
    logic [W-1:0] edges;
    logic         p1_flip;
    logic         reach;

    assign p1_flip = running && half;
    assign reach   = p1_flip && (edges == PRE_LAST);

    // Purpose: drive the REQ and P1 lines and the half-rate phase bit.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            running <= 1'b0;
            req     <= 1'b0;
            p1      <= 1'b0;
            half    <= 1'b0;
        end else if (launch) begin
            running <= 1'b1;
            req     <= 1'b1;
            p1      <= 1'b1;
            half    <= 1'b0;
        end else if (running) begin
            req  <= ~req;
            half <= ~half;
            if (p1_flip) begin
                p1 <= ~p1;
            end
        end
    end

    // Purpose: count P1 transitions and flag the end of the preamble.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            edges      <= '0;
            done_pulse <= 1'b0;
            met        <= 1'b0;
        end else if (launch) begin
            edges      <= W'(1);
            done_pulse <= 1'b0;
            met        <= 1'b0;
        end else begin
            done_pulse <= reach;
            if (reach) begin
                met <= 1'b1;
            end
            if (p1_flip && (edges != LAST)) begin
                edges <= edges + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pace_preamble_seq.sv
// Top of the paced preamble sequencer. A control FSM accepts a start
// request, waits for the setup timer and the selection-quiet guard,
// then launches the strobe generator and holds the phase until start
// drops. One clock tick equals one transfer period. Reset is
// synchronous, active low. Assumes start, prev_was_out and sel_active
// are synchronous to clk.
module pace_preamble_seq #(
    parameter int SHORT_SETUP  = 64,
    parameter int LONG_SETUP   = 128,
    parameter int DESKEW_TICKS = 4,
    parameter int PRE_EDGES    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic prev_was_out,
    input  logic sel_active,
    output logic req_o,
    output logic p1_o,
    output logic phase_active,
    output logic preamble_done,
    output logic data_ok
);
    import pace_pkg::*;

    localparam int QUIET_TICKS = 2 * DESKEW_TICKS;
    localparam int PRE_USED    = (PRE_EDGES < 8) ? 8 : PRE_EDGES;

    pace_state_e state, state_nx;
    logic        tmr_load, tmr_clear, tmr_done;
    logic        bus_quiet;
    logic        gen_launch, gen_halt;

    // Purpose: choose the next state and the one-tick control strobes.
    always_comb begin
        state_nx   = state;
        tmr_load   = 1'b0;
        tmr_clear  = 1'b0;
        gen_launch = 1'b0;
        gen_halt   = 1'b0;
        unique case (state)
            PS_IDLE: begin
                if (start) begin
                    state_nx = PS_SETUP;
                    tmr_load = 1'b1;
                end
            end
            PS_SETUP: begin
                if (!start) begin
                    state_nx  = PS_IDLE;
                    tmr_clear = 1'b1;
                    gen_halt  = 1'b1;
                end else if (tmr_done && bus_quiet) begin
                    state_nx   = PS_RUN;
                    tmr_clear  = 1'b1;
                    gen_launch = 1'b1;
                end
            end
            PS_RUN: begin
                if (!start) begin
                    state_nx = PS_IDLE;
                    gen_halt = 1'b1;
                end
            end
            default: begin
                state_nx  = PS_IDLE;
                tmr_clear = 1'b1;
                gen_halt  = 1'b1;
            end
        endcase
    end

    // Purpose: hold the control state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    pace_setup_timer #(
        .SHORT_TICKS (SHORT_SETUP),
        .LONG_TICKS  (LONG_SETUP)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .use_long (prev_was_out),
        .clear    (tmr_clear),
        .expired  (tmr_done)
    );

    pace_bus_quiet #(
        .QUIET_TICKS (QUIET_TICKS)
    ) u_quiet (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_active (sel_active),
        .quiet_ok   (bus_quiet)
    );

    pace_strobe_gen #(
        .MIN_EDGES (PRE_USED)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (gen_launch),
        .halt       (gen_halt),
        .req        (req_o),
        .p1         (p1_o),
        .done_pulse (preamble_done),
        .met        (data_ok)
    );

    assign phase_active = (state == PS_RUN);

endmodule

// File: rtl/pace_preamble_chk.sv
// Property checker for pace_preamble_seq, attached by bind below.
// Observes ports plus the selection-quiet flag from the guard.
module pace_preamble_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic req_o,
    input logic p1_o,
    input logic phase_active,
    input logic preamble_done,
    input logic data_ok,
    input logic quiet_ok
);

    AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_active |-> (!req_o && !p1_o && !data_ok)) else $error("AST_IDLE_LINES_LOW"); // R1

    AST_LAUNCH_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_active) |-> (req_o && p1_o)) else $error("AST_LAUNCH_TOGETHER"); // R4

    AST_REQ_EVERY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_active && $past(phase_active)) |-> (req_o != $past(req_o))) else $error("AST_REQ_EVERY_TICK"); // R5

    AST_P1_ON_REQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_active && $past(phase_active) && (p1_o != $past(p1_o))) |-> (req_o && !$past(req_o))) else $error("AST_P1_ON_REQ_RISE"); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        preamble_done |=> !preamble_done) else $error("AST_DONE_SINGLE"); // R6

    AST_VALID_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        data_ok |-> phase_active) else $error("AST_VALID_IN_PHASE"); // R7

    AST_DESKEW_MET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_active) |-> $past(quiet_ok)) else $error("AST_DESKEW_MET"); // R8

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !phase_active) else $error("AST_STOP_TO_IDLE"); // R9

endmodule

bind pace_preamble_seq pace_preamble_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .req_o         (req_o),
    .p1_o          (p1_o),
    .phase_active  (phase_active),
    .preamble_done (preamble_done),
    .data_ok       (data_ok),
    .quiet_ok      (bus_quiet)
);

// File: tb/pace_preamble_seq_test.sv
module pace_preamble_seq_test;

    localparam int SHORT = 6;
    localparam int LONG  = 12;
    localparam int DESK  = 2;
    localparam int PRE   = 8;
    localparam int DONE_OFS = 2 * (PRE - 1);

    // {prev_was_out[15], sel release edge r[14:8] (0 = already quiet), expected REQ offset[7:0]}
    localparam int NV = 6;
    localparam logic [15:0] VEC [0:NV-1] = '{
        {1'b0, 7'd0,  8'd6},
        {1'b1, 7'd0,  8'd12},
        {1'b0, 7'd5,  8'd9},
        {1'b1, 7'd10, 8'd14},
        {1'b0, 7'd2,  8'd6},
        {1'b0, 7'd3,  8'd7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic prev_was_out = 1'b0;
    logic sel_active = 1'b0;
    logic req_o, p1_o, phase_active, preamble_done, data_ok;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pace_preamble_seq #(
        .SHORT_SETUP  (SHORT),
        .LONG_SETUP   (LONG),
        .DESKEW_TICKS (DESK),
        .PRE_EDGES    (PRE)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .prev_was_out  (prev_was_out),
        .sel_active    (sel_active),
        .req_o         (req_o),
        .p1_o          (p1_o),
        .phase_active  (phase_active),
        .preamble_done (preamble_done),
        .data_ok       (data_ok)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int all_lines();
        return {req_o, p1_o, phase_active, preamble_done, data_ok};
    endfunction

    // Accept a start, release sel per r, return observed REQ offset (99 if none).
    task automatic launch(input bit prev, input int r, input int glitch_at, output int seen);
        seen = 99;
        @(negedge clk);
        start = 1'b1;
        prev_was_out = prev;
        if (r > 0) sel_active = 1'b1;
        @(negedge clk);
        if (r == 1) sel_active = 1'b0;
        if (req_o) seen = 0;
        for (int k = 1; k < 60 && seen == 99; k++) begin
            @(negedge clk);
            if (req_o) begin
                seen = k;
            end else begin
                if (k == r - 1) sel_active = 1'b0;
                if (prev && k == 1) prev_was_out = 1'b0; // R3: late change ignored
                if (glitch_at > 0 && k == glitch_at) sel_active = 1'b1;
                if (glitch_at > 0 && k == glitch_at + 1) sel_active = 1'b0;
            end
        end
    endtask

    task automatic quiet_idle();
        @(negedge clk);
        start = 1'b0;
        sel_active = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int seen;
        int bad5, bad6, bad7;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(all_lines() == 0, "R1 reset", all_lines(), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            sel_active = i[0];
        end
        @(negedge clk);
        check(all_lines() == 0, "R1 idle with sel activity", all_lines(), 0);

        for (int v = 0; v < NV; v++) begin
            quiet_idle();
            launch(VEC[v][15], int'(VEC[v][14:8]), 0, seen);
            check(seen == int'(VEC[v][7:0]), VEC[v][15] ? "R3 long delay" : "R2/R8 delay",
                  seen, int'(VEC[v][7:0]));
            check(req_o && p1_o && phase_active, "R4 launch together",
                  {req_o, p1_o, phase_active}, 7);
            bad5 = 0; bad6 = 0; bad7 = 0;
            for (int j = 0; j < 22; j++) begin
                if (j > 0) @(negedge clk);
                if (req_o != (j % 2 == 0) || p1_o != ((j / 2) % 2 == 0)) bad5++;
                if (preamble_done != (j == DONE_OFS)) bad6++;
                if (data_ok != (j >= DONE_OFS)) bad7++;
            end
            check(bad5 == 0, "R5 REQ/P1 pattern", bad5, 0);
            check(bad6 == 0, "R6 done pulse timing", bad6, 0);
            check(bad7 == 0, "R7 data_ok hold", bad7, 0);
            start = 1'b0;
            @(negedge clk);
            check({req_o, p1_o, phase_active, data_ok} == 0, "R9 stop in phase",
                  {req_o, p1_o, phase_active, data_ok}, 0);
        end

        // R8: selection glitch during setup restarts the quiet count
        quiet_idle();
        launch(1'b0, 0, 3, seen);
        check(seen == 9, "R8 glitch restart", seen, 9);

        // R9: stop during setup, no REQ afterwards, then a clean restart
        quiet_idle();
        @(negedge clk);
        start = 1'b1;
        prev_was_out = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b0;
        bad5 = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (all_lines() != 0) bad5++;
        end
        check(bad5 == 0, "R9 stop in setup", bad5, 0);
        launch(1'b0, 0, 0, seen);
        check(seen == SHORT, "R9 restart delay", seen, SHORT);

        // R9: synchronous reset in the middle of a phase
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({req_o, p1_o, phase_active, data_ok} == 0, "R9 reset in phase",
              {req_o, p1_o, phase_active, data_ok}, 0);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(all_lines() == 0, "R1 idle after reset", all_lines(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule